// File: doc/BRIEF.md
# Clipped Circle Span Table Generator

This engine fills a scanline-indexed buffer with the horizontal extent of a circle on every line of a 240 by 160 screen. A line-rate transfer engine can then load each line's entry into a window-edge register. The inputs are a start pulse, a signed centre and an unsigned radius. The engine first writes zero to every buffer entry. It then traces the circle with the integer midpoint method and uses eight-way symmetry to get all rows from one octant. Each row it reaches gets a packed left/right span word.

Every edge is clamped to the screen width. Any row that falls off the top or bottom of the screen is skipped. The buffer has one more entry than there are lines. At the end, the engine reads entry 0 back through a one-cycle-latency read port and writes a copy of it into that last entry. A one-cycle done pulse follows.

The engine makes at most one buffer access per clock, so the symmetric writes of each step go out in turn over successive cycles. A start request that arrives while a table is being built is ignored.

Top module: `span_circle_gen`

## Requirements
- R1: A start pulse sampled while the engine is idle captures centre and radius, and the next cycle carries a write of zero to entry 0.
- R2: The clear pass writes zero to entries 0 through 160, one per cycle, in ascending address order, before any span is written.
- R3: A span word holds the clamped right edge in bits 7:0 and the clamped left edge in bits 15:8. Each edge is limited to 0..240, and the left edge never exceeds the right.
- R4: The trace starts at x=0, y=r and d=1-r, and runs while y>=x. Each step first writes row y0-x and then row y0+x, both with the span x0-y..x0+y.
- R5: In a step that begins with d>=0, the engine then writes row y0-y and then row y0+y with the span x0-x..x0+x, decrements y and subtracts twice the new y from d. Every step adds 2·x+3 (old x) to d and increments x.
- R6: A row outside 0..159 gets no write during the trace. No write ever addresses beyond entry 160.
- R7: After the trace, the engine reads entry 0 (address 0, data one cycle later) and writes that data to entry 160 in the next cycle. The read and the write are in consecutive cycles.
- R8: Done is high for exactly one cycle, in the cycle after the entry-160 write.
- R9: A start pulse while the engine is busy has no effect: the centre and radius in use and the write sequence do not change.
- R10: In any cycle the engine performs at most one buffer access; read enable and write enable are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to build a new table |
| ctr_x | input | COORD_W (12) | Signed circle centre column |
| ctr_y | input | COORD_W (12) | Signed circle centre row |
| radius | input | RADIUS_W (8) | Unsigned circle radius |
| buf_we | output | 1 | Buffer write enable |
| buf_waddr | output | 8 | Buffer write address (0..160) |
| buf_wdata | output | 16 | Packed span word {left, right} |
| buf_re | output | 1 | Buffer read enable |
| buf_raddr | output | 8 | Buffer read address |
| buf_rdata | input | 16 | Buffer read data, valid one cycle after buf_re |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the buffer returns read data exactly one cycle after the read request, and that nothing else writes the buffer while a table is being built. The bench keeps to both assumptions: its memory model registers read data on the clock edge after the request and is written only by the engine's write port. The centres in the stimulus stay well inside the signed 12-bit range and radii stay within 8 bits, so the internal sums never wrap. These centres include off-screen positions on every side, which exercise clamping and row rejection.

// File: rtl/span_circle_pkg.sv
package span_circle_pkg;

  // Width of every internal signed sum (centre +/- offset, decision term).
  localparam int CALC_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_TRACE,
    ST_WRAP_RD,
    ST_WRAP_WR,
    ST_DONE
  } scg_state_e;

  // Limit a signed coordinate to 0..lim.
  function automatic logic [CALC_W-1:0] clamp_edge(input logic signed [CALC_W-1:0] v,
                                                   input int lim);
    logic signed [CALC_W-1:0] lim_s;
    lim_s = CALC_W'(lim);
    if (v[CALC_W-1])  return '0;
    if (v > lim_s)    return lim_s;
    return v;
  endfunction

  // True when a signed row index lies in 0..rows-1.
  function automatic logic row_visible(input logic signed [CALC_W-1:0] row,
                                       input int rows);
    logic signed [CALC_W-1:0] rows_s;
    rows_s = CALC_W'(rows);
    return !row[CALC_W-1] && (row < rows_s);
  endfunction

  // Decision update for a step that keeps y.
  function automatic logic signed [CALC_W-1:0] d_keep_y(input logic signed [CALC_W-1:0] d,
                                                        input logic signed [CALC_W-1:0] x);
    return CALC_W'(d + x + x + CALC_W'(3));
  endfunction

  // Decision update for a step that lowers y by one.
  function automatic logic signed [CALC_W-1:0] d_lower_y(input logic signed [CALC_W-1:0] d,
                                                         input logic signed [CALC_W-1:0] x,
                                                         input logic signed [CALC_W-1:0] y);
    logic signed [CALC_W-1:0] y_new;
    y_new = CALC_W'(y - CALC_W'(1));
    return CALC_W'(d - y_new - y_new + x + x + CALC_W'(3));
  endfunction

endpackage

// File: rtl/scg_midpoint.sv
module scg_midpoint
  import span_circle_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic signed [CALC_W-1:0] radius_i,
  input  logic                     adv_keep,
  input  logic                     adv_lower,
  output logic signed [CALC_W-1:0] x_o,
  output logic signed [CALC_W-1:0] y_o,
  output logic                     more_o,
  output logic                     lower_o
);

  logic signed [CALC_W-1:0] x_q, y_q, d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
      d_q <= '0;
    end else if (load) begin
      x_q <= '0;
      y_q <= radius_i;
      d_q <= CALC_W'(CALC_W'(1) - radius_i);
    end else if (adv_lower) begin
      d_q <= d_lower_y(d_q, x_q, y_q);
      y_q <= CALC_W'(y_q - CALC_W'(1));
      x_q <= CALC_W'(x_q + CALC_W'(1));
    end else if (adv_keep) begin
      d_q <= d_keep_y(d_q, x_q);
      x_q <= CALC_W'(x_q + CALC_W'(1));
    end
  end

  assign x_o     = x_q;
  assign y_o     = y_q;
  assign more_o  = (y_q >= x_q);
  assign lower_o = !d_q[CALC_W-1];

endmodule

// File: rtl/scg_slot_seq.sv
module scg_slot_seq #(
  parameter int SLOTS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     active,
  input  logic                     more,
  input  logic                     lower,
  output logic [$clog2(SLOTS)-1:0] slot_o,
  output logic                     adv_keep,
  output logic                     adv_lower,
  output logic                     finish
);

  localparam int SW = $clog2(SLOTS);
  localparam logic [SW-1:0] SIDE_LAST = SW'(SLOTS/2 - 1);
  localparam logic [SW-1:0] DIAG_LAST = SW'(SLOTS - 1);

  logic [SW-1:0] slot_q;

  assign finish    = active && (slot_q == '0) && !more;
  assign adv_keep  = active && (slot_q == SIDE_LAST) && !lower;
  assign adv_lower = active && (slot_q == DIAG_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else if (!active || finish || adv_keep || adv_lower) begin
      slot_q <= '0;
    end else begin
      slot_q <= SW'(slot_q + 1'b1);
    end
  end

  assign slot_o = slot_q;

endmodule

// File: rtl/scg_span_calc.sv
module scg_span_calc
  import span_circle_pkg::*;
#(
  parameter int SCREEN_W = 240,
  parameter int SCREEN_H = 160,
  parameter int EDGE_W   = 8,
  localparam int WORD_W  = 2 * EDGE_W
) (
  input  logic signed [CALC_W-1:0] cx,
  input  logic signed [CALC_W-1:0] cy,
  input  logic signed [CALC_W-1:0] x,
  input  logic signed [CALC_W-1:0] y,
  input  logic [1:0]               slot,
  output logic signed [CALC_W-1:0] row_o,
  output logic                     row_ok_o,
  output logic [WORD_W-1:0]        word_o
);

  logic signed [CALC_W-1:0] half, vofs;
  logic [CALC_W-1:0]        left_c, right_c;

  always_comb begin
    // slots 0/1: side octants; slots 2/3: top/bottom octants
    half = slot[1] ? x : y;
    vofs = slot[1] ? y : x;
    row_o = slot[0] ? CALC_W'(cy + vofs) : CALC_W'(cy - vofs);
    left_c  = clamp_edge(CALC_W'(cx - half), SCREEN_W);
    right_c = clamp_edge(CALC_W'(cx + half), SCREEN_W);
    word_o  = {left_c[EDGE_W-1:0], right_c[EDGE_W-1:0]};
    row_ok_o = row_visible(row_o, SCREEN_H);
  end

endmodule

// File: rtl/span_circle_gen.sv
module span_circle_gen
  import span_circle_pkg::*;
#(
  parameter int SCREEN_W  = 240,
  parameter int SCREEN_H  = 160,
  parameter int COORD_W   = 12,
  parameter int RADIUS_W  = 8,
  localparam int ENTRIES  = SCREEN_H + 1,
  localparam int ADDR_W   = $clog2(ENTRIES),
  localparam int EDGE_W   = $clog2(SCREEN_W + 1),
  localparam int WORD_W   = 2 * EDGE_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic signed [COORD_W-1:0]  ctr_x,
  input  logic signed [COORD_W-1:0]  ctr_y,
  input  logic [RADIUS_W-1:0]        radius,
  output logic                       buf_we,
  output logic [ADDR_W-1:0]          buf_waddr,
  output logic [WORD_W-1:0]          buf_wdata,
  output logic                       buf_re,
  output logic [ADDR_W-1:0]          buf_raddr,
  input  logic [WORD_W-1:0]          buf_rdata,
  output logic                       done
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(SCREEN_H);

  scg_state_e               state;
  logic [ADDR_W-1:0]        clr_idx;
  logic signed [CALC_W-1:0] cx_q, cy_q;
  logic [RADIUS_W-1:0]      r_q;

  // named internal events
  logic is_idle, clear_wr, trace_wr, wrap_wr, load_trace;
  logic trace_on, more, lower, adv_keep, adv_lower, finish;
  logic [1:0] slot;
  logic signed [CALC_W-1:0] x_cur, y_cur, row;
  logic row_ok;
  logic [WORD_W-1:0] span_word;

  assign is_idle    = (state == ST_IDLE);
  assign trace_on   = (state == ST_TRACE);
  assign load_trace = (state == ST_CLEAR) && (clr_idx == LAST_ADDR);

  scg_midpoint u_mid (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_trace),
    .radius_i  ($signed({{(CALC_W-RADIUS_W){1'b0}}, r_q})),
    .adv_keep  (adv_keep),
    .adv_lower (adv_lower),
    .x_o       (x_cur),
    .y_o       (y_cur),
    .more_o    (more),
    .lower_o   (lower)
  );

  scg_slot_seq #(.SLOTS(4)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (trace_on),
    .more      (more),
    .lower     (lower),
    .slot_o    (slot),
    .adv_keep  (adv_keep),
    .adv_lower (adv_lower),
    .finish    (finish)
  );

  scg_span_calc #(
    .SCREEN_W (SCREEN_W),
    .SCREEN_H (SCREEN_H),
    .EDGE_W   (EDGE_W)
  ) u_span (
    .cx       (cx_q),
    .cy       (cy_q),
    .x        (x_cur),
    .y        (y_cur),
    .slot     (slot),
    .row_o    (row),
    .row_ok_o (row_ok),
    .word_o   (span_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      clr_idx <= '0;
      cx_q    <= '0;
      cy_q    <= '0;
      r_q     <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          cx_q    <= {{(CALC_W-COORD_W){ctr_x[COORD_W-1]}}, ctr_x};
          cy_q    <= {{(CALC_W-COORD_W){ctr_y[COORD_W-1]}}, ctr_y};
          r_q     <= radius;
          clr_idx <= '0;
          state   <= ST_CLEAR;
        end
        ST_CLEAR: begin
          clr_idx <= ADDR_W'(clr_idx + 1'b1);
          if (clr_idx == LAST_ADDR) state <= ST_TRACE;
        end
        ST_TRACE:   if (finish) state <= ST_WRAP_RD;
        ST_WRAP_RD: state <= ST_WRAP_WR;
        ST_WRAP_WR: state <= ST_DONE;
        ST_DONE:    state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  assign clear_wr = (state == ST_CLEAR);
  assign trace_wr = trace_on && !finish && row_ok;
  assign wrap_wr  = (state == ST_WRAP_WR);

  always_comb begin
    buf_we = clear_wr || trace_wr || wrap_wr;
    if (clear_wr) begin
      buf_waddr = clr_idx;
      buf_wdata = '0;
    end else if (wrap_wr) begin
      buf_waddr = LAST_ADDR;
      buf_wdata = buf_rdata;
    end else begin
      buf_waddr = row[ADDR_W-1:0];
      buf_wdata = span_word;
    end
  end

  assign buf_re    = (state == ST_WRAP_RD);
  assign buf_raddr = '0;
  assign done      = (state == ST_DONE);

endmodule

// File: rtl/scg_checker.sv
module scg_checker #(
  parameter int ADDR_W   = 8,
  parameter int WORD_W   = 16,
  parameter int CALC_W   = 16,
  parameter int RADIUS_W = 8,
  parameter int EDGE_LIM = 240,
  parameter int LAST_ROW = 160
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start,
  input logic                     is_idle,
  input logic                     clear_wr,
  input logic                     trace_wr,
  input logic                     wrap_wr,
  input logic                     buf_we,
  input logic [ADDR_W-1:0]        buf_waddr,
  input logic [WORD_W-1:0]        buf_wdata,
  input logic                     buf_re,
  input logic [ADDR_W-1:0]        buf_raddr,
  input logic [WORD_W-1:0]        buf_rdata,
  input logic                     done,
  input logic signed [CALC_W-1:0] x_cur,
  input logic signed [CALC_W-1:0] y_cur,
  input logic signed [CALC_W-1:0] cx_q,
  input logic signed [CALC_W-1:0] cy_q,
  input logic [RADIUS_W-1:0]      r_q
);

  localparam int EW = WORD_W / 2;
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST_ROW);
  localparam logic [EW-1:0]     LIM    = EW'(EDGE_LIM);

  p_clear_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && is_idle) |=> (buf_we && buf_waddr == '0 && buf_wdata == '0));

  p_clear_ascend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_wr && buf_waddr != LAST_A) |=>
      (clear_wr && buf_waddr == ADDR_W'($past(buf_waddr) + 1'b1) && buf_wdata == '0));

  p_edge_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (buf_wdata[EW-1:0] <= LIM && buf_wdata[WORD_W-1:EW] <= LIM));

  p_span_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trace_wr |-> (buf_wdata[WORD_W-1:EW] <= buf_wdata[EW-1:0]));

  p_octant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trace_wr |-> (!x_cur[CALC_W-1] && y_cur >= x_cur));

  p_row_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trace_wr |-> (buf_waddr < LAST_A));

  p_addr_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (buf_waddr <= LAST_A));

  p_wrap_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_re |=> (wrap_wr && buf_we && buf_waddr == LAST_A && buf_wdata == buf_rdata));

  p_wrap_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_re |-> (buf_raddr == '0));

  p_done_after_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_wr |=> done);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !is_idle |=> ($stable(cx_q) && $stable(cy_q) && $stable(r_q)));

  p_one_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_re && buf_we));

endmodule

bind span_circle_gen scg_checker #(
  .ADDR_W   (ADDR_W),
  .WORD_W   (WORD_W),
  .CALC_W   (span_circle_pkg::CALC_W),
  .RADIUS_W (RADIUS_W),
  .EDGE_LIM (SCREEN_W),
  .LAST_ROW (SCREEN_H)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .is_idle   (is_idle),
  .clear_wr  (clear_wr),
  .trace_wr  (trace_wr),
  .wrap_wr   (wrap_wr),
  .buf_we    (buf_we),
  .buf_waddr (buf_waddr),
  .buf_wdata (buf_wdata),
  .buf_re    (buf_re),
  .buf_raddr (buf_raddr),
  .buf_rdata (buf_rdata),
  .done      (done),
  .x_cur     (x_cur),
  .y_cur     (y_cur),
  .cx_q      (cx_q),
  .cy_q      (cy_q),
  .r_q       (r_q)
);

// File: tb/span_circle_gen_tb.sv
`timescale 1ns/1ps
module span_circle_gen_tb;

  localparam int SW = 240;
  localparam int SH = 160;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic               rst_n, start;
  logic signed [11:0] ctr_x, ctr_y;
  logic [7:0]         radius;
  logic               buf_we, buf_re, done;
  logic [7:0]         buf_waddr, buf_raddr;
  logic [15:0]        buf_wdata, buf_rdata;

  span_circle_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ctr_x(ctr_x), .ctr_y(ctr_y), .radius(radius),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .buf_re(buf_re), .buf_raddr(buf_raddr), .buf_rdata(buf_rdata),
    .done(done)
  );

  // buffer model: one-cycle read latency
  logic [15:0] mem [0:SH];
  always @(posedge clk) begin
    if (buf_we && buf_waddr <= 8'(SH)) mem[buf_waddr] <= buf_wdata;
    if (buf_re) buf_rdata <= mem[buf_raddr];
  end

  typedef struct { int addr; int data; string tag; } exp_t;
  exp_t expq[$];
  exp_t e;
  int   ref_tab [0:SH];
  int   n_cmp = 0, n_bad = 0, done_cnt = 0;
  bit   prev_wrap = 0, finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // monitor: pops expected writes as the design makes them
  always @(negedge clk) begin
    if (rst_n) begin
      if (buf_we) begin
        if (expq.size() == 0) begin
          check(0, "R6 unexpected write addr", int'(buf_waddr), -1);
        end else begin
          e = expq.pop_front();
          n_cmp++;
          if (int'(buf_waddr) != e.addr || int'(buf_wdata) != e.data) begin
            n_bad++;
            $display("FAIL %s: write addr %0d data %h, expected addr %0d data %h",
                     e.tag, buf_waddr, buf_wdata, e.addr, e.data[15:0]);
          end
        end
      end
      if (done) begin
        done_cnt++;
        check(prev_wrap, "R8 done follows entry-160 write", int'(prev_wrap), 1);
      end
      prev_wrap = buf_we && (int'(buf_waddr) == SH);
    end
  end

  function automatic int clampe(input int v);
    if (v < 0) return 0;
    if (v > SW) return SW;
    return v;
  endfunction

  task automatic put_row(input int row, input int lft, input int rgt, input string tag);
    int w;
    w = (clampe(lft) << 8) | clampe(rgt);
    if (row >= 0 && row < SH) begin   // R6: rows off screen are dropped
      expq.push_back('{row, w, tag});
      ref_tab[row] = w;
    end
  endtask

  // driver side: build the expected write stream
  task automatic expect_table(input int x0, input int y0, input int rr);
    int x, y, d;
    for (int i = 0; i <= SH; i++) begin
      ref_tab[i] = 0;
      expq.push_back('{i, 0, (i == 0) ? "R1" : "R2"});
    end
    x = 0; y = rr; d = 1 - rr;
    while (y >= x) begin
      put_row(y0 - x, x0 - y, x0 + y, "R4");
      put_row(y0 + x, x0 - y, x0 + y, "R4");
      if (d >= 0) begin
        put_row(y0 - y, x0 - x, x0 + x, "R5");
        put_row(y0 + y, x0 - x, x0 + x, "R5");
        y = y - 1;
        d = d - 2 * y;
      end
      d = d + 2 * x + 3;
      x = x + 1;
    end
    expq.push_back('{SH, ref_tab[0], "R7"});
  endtask

  task automatic run_case(input int x0, input int y0, input int rr, input bit poke);
    int base, cyc;
    expect_table(x0, y0, rr);
    base = done_cnt;
    @(negedge clk);
    ctr_x = 12'(x0); ctr_y = 12'(y0); radius = 8'(rr); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R9: requests during clear and during trace must be ignored
      repeat (50) @(negedge clk);
      ctr_x = 12'(5); ctr_y = 12'(5); radius = 8'(9); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (130) @(negedge clk);
      ctr_x = 12'(200); ctr_y = 12'(20); radius = 8'(3); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (done_cnt == base && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    check(done_cnt == base + 1, "R8 done seen", done_cnt - base, 1);
    repeat (3) @(negedge clk);
    check(done_cnt == base + 1, "R8 single done pulse", done_cnt - base, 1);
    check(expq.size() == 0, "R4 all expected writes produced", expq.size(), 0);
    check(mem[SH] == mem[0], "R7 wrap entry equals entry 0", int'(mem[SH]), int'(mem[0]));
    expq.delete();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; ctr_x = '0; ctr_y = '0; radius = '0;
    repeat (4) @(negedge clk);
    check(!buf_we, "R10 no write in reset", int'(buf_we), 0);
    check(!done, "R8 done low in reset", int'(done), 0);
    check(!buf_re, "R10 no read in reset", int'(buf_re), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!buf_we && !done, "R1 idle after reset", int'(buf_we), 0);

    run_case(120, 80, 40, 1'b0);   // fully visible circle
    run_case(0, 0, 30, 1'b0);      // corner: clamping (R3) and row rejection (R6)
    run_case(230, 150, 60, 1'b0);  // right/bottom clipping R3 R6
    run_case(10, 5, 0, 1'b0);      // zero radius
    run_case(120, 80, 255, 1'b0);  // largest radius, every edge clamped
    run_case(-50, 200, 100, 1'b0); // centre off screen
    run_case(60, -300, 20, 1'b0);  // nothing visible: only clear and wrap R6
    run_case(300, -20, 50, 1'b0);  // centre right of screen
    run_case(100, 60, 35, 1'b1);   // R9 busy starts ignored
    run_case(40, 100, 12, 1'b0);   // fresh start after ignored requests

    finish_run();
  end

endmodule